// File: doc/BRIEF.md
# Weighted Threshold Voter

This block combines a vote with an input switch. It takes a set of single-bit votes. Each vote has its own small unsigned weight, and software sets that weight. The block adds up the weights of the votes that are 1. It compares that total against a programmable threshold and registers the result. The output goes high when the total is greater than or equal to the threshold.

Setting every weight to 1 turns the block into a plain m-out-of-n voter, with the threshold as m. A threshold of floor(n/2)+1 makes it a majority voter. Giving a source a larger weight lets a more trusted source count for more. A weight of zero removes a source from the vote entirely, so the same block can switch out a failed source.

The weights and the threshold sit in a small configuration register. That register is written from the configuration inputs whenever the load strobe is high at a clock edge.

Top module: `wthresh_voter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output becomes 0, every weight becomes 1 and the threshold becomes floor(N_VOTES/2)+1. Out of reset, the block therefore acts as a majority voter.
- R2: The output at each clock edge is 1 exactly when the sum of the weights of the votes sampled at that edge, counting only votes that are 1, is greater than or equal to the stored threshold. The result appears one cycle after the votes.
- R3: A vote whose weight is 0 never adds to the sum. The output is the same whatever value that vote has.
- R4: A stored threshold of 0 makes the output 1 for every vote pattern.
- R5: A stored threshold greater than N_VOTES times the largest weight makes the output 0 for every vote pattern.
- R6: When `cfg_load` is high at a clock edge, the weights and the threshold are stored at that edge. The output first uses them at the following edge. While `cfg_load` is low, changes on `cfg_weights` and `cfg_thresh` have no effect.
- R7: The weight of vote i is taken from `cfg_weights[i*WEIGHT_W +: WEIGHT_W]`.
- R8: The sum never overflows. With every weight at its maximum and every vote at 1, the sum equals N_VOTES times the maximum weight, and a threshold of that value gives an output of 1.
- R9: With four votes, weights 2, 2, 1, 1 and a threshold of 4, the output is 1 in two cases:
  - votes 0 and 1 are both 1;
  - one of votes 0 and 1 is 1, and votes 2 and 3 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the weights and the threshold |
| cfg_weights | input | N_VOTES*WEIGHT_W | Packed weights; vote i at bits i*WEIGHT_W upward |
| cfg_thresh | input | SUM_W | Threshold value |
| votes | input | N_VOTES | Single-bit votes |
| vote_out | output | 1 | Registered vote result |

## Verification
The bench sweeps all sixteen vote patterns under several weight sets. It also sweeps every threshold from 0 to the top of the threshold field against one fixed weight set. Each result is compared with a sum computed arithmetically in the bench.

- Threshold 0: a design that uses a strict greater-than compare would give 0 for the all-zero vote pattern.
- Threshold above the largest possible sum: a design with a sum that is too narrow would wrap the sum and vote 1.
- All weights at maximum: the same narrow sum would fail the case where the threshold equals the full sum.
- A mis-sliced packed weight vector would give the wrong result under weights 2, 2, 1, 1, and so would a purged input that still counts.
- Load timing: the bench changes the configuration in the same cycle as the votes. This exposes a load that takes effect a cycle early, or a configuration that follows the inputs without the strobe.

// File: rtl/wv_pkg.sv
// Package wv_pkg
// Shared helper for sizing the weighted voter. Assumes a weight width
// of at least 1 bit and at least one vote.
package wv_pkg;

    // Bits needed to hold n_votes times the largest weight without overflow.
    function automatic int sum_bits(int n_votes, int weight_w);
        return $clog2(n_votes * ((1 << weight_w) - 1) + 1);
    endfunction

endpackage

// File: rtl/wv_cfg_regs.sv
// Module wv_cfg_regs
// Holds the per-vote weights and the threshold. It loads both from the
// configuration inputs on any edge where the load strobe is high, and
// keeps them otherwise. The reset state is a majority voter: every
// weight 1 and a threshold of floor(n/2)+1.
module wv_cfg_regs #(
    parameter int N_VOTES  = 4,
    parameter int WEIGHT_W = 3,
    parameter int SUM_W    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_load,
    input  logic [N_VOTES*WEIGHT_W-1:0]   cfg_weights,
    input  logic [SUM_W-1:0]              cfg_thresh,
    output logic [N_VOTES*WEIGHT_W-1:0]   weights_q,
    output logic [SUM_W-1:0]              thresh_q
);

    localparam logic [N_VOTES*WEIGHT_W-1:0] RST_WEIGHTS = {N_VOTES{WEIGHT_W'(1)}};
    localparam logic [SUM_W-1:0]            RST_THRESH  = SUM_W'(N_VOTES / 2 + 1);

    // Configuration storage: reset to a majority voter, load on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            weights_q <= RST_WEIGHTS;
            thresh_q  <= RST_THRESH;
        end else if (cfg_load) begin
            weights_q <= cfg_weights;
            thresh_q  <= cfg_thresh;
        end
    end

    // R6: a strobe stores exactly what the configuration inputs held.
    a_r6_load_weights: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (weights_q == $past(cfg_weights)) && (thresh_q == $past(cfg_thresh)));

    // R6: without a strobe, the stored configuration is left as it was.
    a_r6_hold_config: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(weights_q) && $stable(thresh_q));

endmodule

// File: rtl/wv_weighted_sum.sv
// Module wv_weighted_sum
// Combinational sum of the weights of the votes that are 1. Each weight
// is gated by its own vote, widened to the sum width and then added.
// Assumes SUM_W is large enough for N_VOTES times the largest weight.
module wv_weighted_sum #(
    parameter int N_VOTES  = 4,
    parameter int WEIGHT_W = 3,
    parameter int SUM_W    = 5
) (
    input  logic [N_VOTES-1:0]            votes,
    input  logic [N_VOTES*WEIGHT_W-1:0]   weights,
    output logic [SUM_W-1:0]              sum
);

    logic [SUM_W-1:0] gated [N_VOTES];

    for (genvar gi = 0; gi < N_VOTES; gi++) begin : g_gate
        // Pass this input's weight only when its vote is 1.
        assign gated[gi] = votes[gi] ? SUM_W'(weights[gi*WEIGHT_W +: WEIGHT_W]) : '0;
    end

    // Add up the gated weights.
    always_comb begin
        sum = '0;
        for (int i = 0; i < N_VOTES; i++) begin
            sum = sum + gated[i];
        end
    end

    // R3: when every weight is zero, no vote can contribute to the sum.
    always_comb begin
        if (weights == '0) begin
            a_r3_purged_sum: assert (sum == '0);
        end
    end

endmodule

// File: rtl/wv_decide.sv
// Module wv_decide
// Compares the weighted sum against the threshold and registers the
// result. A greater-or-equal compare is used, so a threshold of zero
// always gives an output of 1.
module wv_decide #(
    parameter int SUM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] sum,
    input  logic [SUM_W-1:0] thresh,
    output logic             decision
);

    // Register the compare result every cycle; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            decision <= 1'b0;
        end else begin
            decision <= (sum >= thresh);
        end
    end

endmodule

// File: rtl/wthresh_voter.sv
// Module wthresh_voter
// Top of the weighted threshold voter. It chains three stages:
//   - the configuration registers;
//   - the gated weight adder;
//   - the registered compare.
// Assumes the votes are synchronous to clk.
module wthresh_voter #(
    parameter  int N_VOTES  = 4,
    parameter  int WEIGHT_W = 3,
    localparam int SUM_W    = wv_pkg::sum_bits(N_VOTES, WEIGHT_W)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_load,
    input  logic [N_VOTES*WEIGHT_W-1:0]   cfg_weights,
    input  logic [SUM_W-1:0]              cfg_thresh,
    input  logic [N_VOTES-1:0]            votes,
    output logic                          vote_out
);

    localparam int MAX_SUM = N_VOTES * ((1 << WEIGHT_W) - 1);

    logic [N_VOTES*WEIGHT_W-1:0] weights_q;
    logic [SUM_W-1:0]            thresh_q;
    logic [SUM_W-1:0]            sum;

    wv_cfg_regs #(
        .N_VOTES (N_VOTES),
        .WEIGHT_W(WEIGHT_W),
        .SUM_W   (SUM_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_weights(cfg_weights),
        .cfg_thresh (cfg_thresh),
        .weights_q  (weights_q),
        .thresh_q   (thresh_q)
    );

    wv_weighted_sum #(
        .N_VOTES (N_VOTES),
        .WEIGHT_W(WEIGHT_W),
        .SUM_W   (SUM_W)
    ) u_sum (
        .votes  (votes),
        .weights(weights_q),
        .sum    (sum)
    );

    wv_decide #(
        .SUM_W(SUM_W)
    ) u_decide (
        .clk     (clk),
        .rst_n   (rst_n),
        .sum     (sum),
        .thresh  (thresh_q),
        .decision(vote_out)
    );

    // R4: a stored threshold of zero gives 1 on the next edge.
    a_r4_zero_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh_q == '0) |=> vote_out);

    // R5: a threshold above the largest possible sum gives 0 on the next edge.
    a_r5_unreachable: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(thresh_q) > MAX_SUM) |=> !vote_out);

    // R3: with every input purged and a nonzero threshold, the vote fails.
    a_r3_all_purged: assert property (@(posedge clk) disable iff (!rst_n)
        ((weights_q == '0) && (thresh_q != '0)) |=> !vote_out);

endmodule

// File: tb/wthresh_voter_tb.sv
`timescale 1ns/1ps
module wthresh_voter_tb;

    localparam int N  = 4;
    localparam int WW = 3;
    localparam int SW = wv_pkg::sum_bits(N, WW);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_load = 1'b0;
    logic [N*WW-1:0]   cfg_weights = '0;
    logic [SW-1:0]     cfg_thresh = '0;
    logic [N-1:0]      votes = '0;
    logic              vote_out;

    int checks = 0;
    int errors = 0;
    int mw [N];
    int mthr;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wthresh_voter #(.N_VOTES(N), .WEIGHT_W(WW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_weights(cfg_weights),
        .cfg_thresh(cfg_thresh), .votes(votes), .vote_out(vote_out)
    );

    // Expected output from the requirements: weighted sum >= threshold.
    function automatic bit model(logic [N-1:0] v);
        int s = 0;
        for (int i = 0; i < N; i++) if (v[i]) s += mw[i];
        return s >= mthr;
    endfunction

    task automatic check(logic act, logic exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: votes=%b thr=%0d actual=%b expected=%b", req, votes, mthr, act, exp);
        end
    endtask

    // Store a configuration and mirror it in the bench model.
    task automatic load(int w0, int w1, int w2, int w3, int thr);
        @(negedge clk);
        cfg_weights = {WW'(w3), WW'(w2), WW'(w1), WW'(w0)};
        cfg_thresh  = SW'(thr);
        cfg_load    = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        mw[0] = w0; mw[1] = w1; mw[2] = w2; mw[3] = w3; mthr = thr;
    endtask

    // Present every vote pattern and check the registered result.
    task automatic sweep(string req);
        for (int v = 0; v < (1 << N); v++) begin
            @(negedge clk);
            votes = N'(v);
            @(negedge clk);
            check(vote_out, model(votes), req);
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        votes = '1;
        repeat (3) @(negedge clk);
        check(vote_out, 1'b0, "R1");               // R1 output cleared in reset
        rst_n = 1'b1;
        mw = '{1, 1, 1, 1}; mthr = N / 2 + 1;
        sweep("R1");                               // R1 default majority voter

        // R6 timing: load and votes in the same cycle; old config used first.
        @(negedge clk);
        votes = '0; cfg_weights = '0; cfg_thresh = '0; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        check(vote_out, 1'b0, "R6");
        @(negedge clk);
        check(vote_out, 1'b1, "R6");

        load(2, 2, 1, 1, 4);  sweep("R9");         // R9 example weights
        load(1, 2, 4, 0, 3);  sweep("R7");         // R7 distinct slice weights
        load(3, 0, 5, 0, 4);  sweep("R3");         // R3 purged inputs
        load(0, 0, 0, 0, 1);  sweep("R3");
        load(7, 7, 7, 7, 28); sweep("R8");         // R8 full sum, no overflow
        load(7, 7, 7, 7, 29); sweep("R5");         // R5 unreachable threshold
        load(7, 7, 7, 7, 31); sweep("R5");
        load(5, 6, 7, 3, 0);  sweep("R4");         // R4 zero threshold

        // R6 ignored: change config inputs without the strobe.
        @(negedge clk);
        cfg_weights = '1; cfg_thresh = '1;
        sweep("R6");

        // R2 threshold sweep over all patterns.
        for (int t = 0; t < (1 << SW); t++) begin
            load(7, 5, 3, 1, t);
            sweep("R2");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule